// File: doc/BRIEF.md
# Start-up Clock and Reset Release Sequencer

This block decides when the processor core may start after an external reset or after a wake-up from power-down. It first filters and synchronises the external reset pin. It then waits for an interval counted in ticks of the low-frequency (32 kHz) timebase, and only after that does it enable the core's system clock. The wait is long if the low-frequency oscillator is reported stopped when the wait begins, because it must start up and the PLLs must settle. The wait is short if the oscillator is already running and only the PLLs must settle.

A start caused by reset keeps the core reset asserted for a fixed number of system-clock cycles after the clock is enabled. This ensures the core sees clocked reset edges. A start caused by wake-up never asserts the core reset. Oscillator and PLL physics are not modelled: the tick strobe and the oscillator-running flag arrive as inputs in the system-clock domain.

States and transitions. `ST_IDLE` (powered down, clock gated) moves to `ST_WAIT_OSC` on a wake request (wake-up transition). `ST_WAIT_OSC` moves to `ST_CLK_ON_RESET` when the wait expires after a reset (reset release transition), or to `ST_RUN` when it expires after a wake-up (wake release transition). `ST_CLK_ON_RESET` moves to `ST_RUN` when the overlap count expires (overlap end transition). `ST_RUN` moves to `ST_IDLE` on a power-down request (sleep transition). A filtered external reset forces `ST_WAIT_OSC` from every state (reset restart transition). Power-on reset also enters `ST_WAIT_OSC` as a reset-type start with the long wait.

Top module: `rst_stretch_seq`

## Requirements
- R1: The external reset counts only once it has been sampled high at FILT_CYC consecutive rising clock edges after a two-flop synchroniser. A shorter high pulse leaves `clk_en` and `core_rst` unchanged.
- R2: Once recognised, the external reset drives `clk_en` to 0 and `core_rst` to 1 from any state. This holds from the second edge after the FILT_CYC-th high sample and lasts while the pin stays high.
- R3: Each wait is SHORT_TICKS ticks if `osc_running` is 1 at the edge that starts it, and LONG_TICKS ticks otherwise. A wait is started by every edge at which the filtered reset is active, and by a wake request taken in `ST_IDLE`.
- R4: `clk_en` stays 0 for the whole wait. A tick is one edge with `tick_32k` high while waiting. `clk_en` becomes 1 at the edge after the edge that counted the last tick.
- R5: After a reset-type wait, `core_rst` stays 1 through the wait and for exactly OVL_CYC cycles with `clk_en` = 1, then falls to 0.
- R6: A start from a wake request never raises `core_rst`.
- R7: In `ST_IDLE` both outputs are 0. `pwr_down` in `ST_RUN` enters `ST_IDLE` at the next edge. `pwr_down` outside `ST_RUN` and `wake_req` outside `ST_IDLE` have no effect.
- R8: Right after `por_n` is released, the block is in a reset-type long wait, with `clk_en` = 0 and `core_rst` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_in | input | 1 | Raw external reset pin, active high, asynchronous |
| wake_req | input | 1 | Wake-up request, honoured in `ST_IDLE` |
| osc_running | input | 1 | Low-frequency oscillator is already running |
| tick_32k | input | 1 | One-cycle strobe per 32 kHz period, synchronous to `clk` |
| pwr_down | input | 1 | Power-down request, honoured in `ST_RUN` |
| clk_en | output | 1 | Enable for the core's system clock |
| core_rst | output | 1 | Stretched reset to the core, active high |

## Verification
A filtered reset reaches the outputs FILT_CYC+2 edges after the first high sample. Every other result follows from registered state: the clock enable appears one edge after the final tick, and the reset falls OVL_CYC edges after that. A wake or power-down request acts one edge after it is sampled. The bench drives every input on the falling edge. It advances a behavioural model on each rising edge and compares both outputs against it on every falling edge, so each result is checked in the exact cycle it is due. Directed checks then measure wait lengths in ticks, the overlap length, and the absence of reset during wake-ups.

// File: rtl/rst_seq_pkg.sv
`timescale 1ns/1ps
package rst_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE         = 2'd0,
        ST_WAIT_OSC     = 2'd1,
        ST_CLK_ON_RESET = 2'd2,
        ST_RUN          = 2'd3
    } seq_state_e;

endpackage

// File: rtl/rst_pin_filter.sv
`timescale 1ns/1ps
module rst_pin_filter #(
    parameter int FILT_CYC = 200
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_raw,
    output logic pin_valid
);
    localparam int CNT_W = $clog2(FILT_CYC + 1);

    logic             sync1_q;
    logic             sync2_q;
    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= pin_raw;
            sync2_q <= sync1_q;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            run_q <= '0;
        end else if (!sync2_q) begin
            run_q <= '0;
        end else if (run_q != CNT_W'(FILT_CYC)) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign pin_valid = (run_q == CNT_W'(FILT_CYC));

    // R1: recognition only ever follows a synchronised high sample
    a_r1_valid_needs_sync: assert property (@(posedge clk) disable iff (!por_n)
        $rose(pin_valid) |-> $past(sync2_q))
        else $error("a_r1_valid_needs_sync");

    // R1: a low synchronised sample always withdraws recognition
    a_r1_low_clears: assert property (@(posedge clk) disable iff (!por_n)
        !sync2_q |=> !pin_valid)
        else $error("a_r1_low_clears");

endmodule

// File: rtl/seq_downcnt.sv
`timescale 1ns/1ps
module seq_downcnt #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    // never wraps below zero
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!por_n)
        (zero && !load) |=> zero)
        else $error("a_r4_no_wrap");

endmodule

// File: rtl/rst_stretch_seq.sv
`timescale 1ns/1ps
module rst_stretch_seq
    import rst_seq_pkg::*;
#(
    parameter int FILT_CYC    = 200,
    parameter int LONG_TICKS  = 18350,
    parameter int SHORT_TICKS = 328,
    parameter int OVL_CYC     = 9000
) (
    input  logic clk,
    input  logic por_n,
    input  logic ext_rst_in,
    input  logic wake_req,
    input  logic osc_running,
    input  logic tick_32k,
    input  logic pwr_down,
    output logic clk_en,
    output logic core_rst
);
    localparam int MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int WAIT_W    = $clog2(MAX_TICKS + 1);
    localparam int OVL_W     = $clog2(OVL_CYC + 1);

    seq_state_e      st_q, st_d;
    logic            from_rst_q, from_rst_d;
    logic            rst_active;
    logic            wait_load, wait_dec, wait_zero;
    logic            ovl_load, ovl_dec, ovl_zero;
    logic [WAIT_W-1:0] wait_val;

    rst_pin_filter #(.FILT_CYC(FILT_CYC)) u_filter (
        .clk       (clk),
        .por_n     (por_n),
        .pin_raw   (ext_rst_in),
        .pin_valid (rst_active)
    );

    assign wait_val = osc_running ? WAIT_W'(SHORT_TICKS) : WAIT_W'(LONG_TICKS);
    assign wait_dec = tick_32k && (st_q == ST_WAIT_OSC);
    assign ovl_dec  = (st_q == ST_CLK_ON_RESET);

    seq_downcnt #(.W(WAIT_W), .RST_VAL(LONG_TICKS)) u_wait_cnt (
        .clk      (clk),
        .por_n    (por_n),
        .load     (wait_load),
        .load_val (wait_val),
        .dec      (wait_dec),
        .zero     (wait_zero)
    );

    seq_downcnt #(.W(OVL_W), .RST_VAL(0)) u_ovl_cnt (
        .clk      (clk),
        .por_n    (por_n),
        .load     (ovl_load),
        .load_val (OVL_W'(OVL_CYC - 1)),
        .dec      (ovl_dec),
        .zero     (ovl_zero)
    );

    // next-state logic
    always_comb begin
        st_d       = st_q;
        from_rst_d = from_rst_q;
        wait_load  = 1'b0;
        ovl_load   = 1'b0;
        if (rst_active) begin
            st_d       = ST_WAIT_OSC;
            from_rst_d = 1'b1;
            wait_load  = 1'b1;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (wake_req) begin
                        st_d       = ST_WAIT_OSC;
                        from_rst_d = 1'b0;
                        wait_load  = 1'b1;
                    end
                end
                ST_WAIT_OSC: begin
                    if (wait_zero) begin
                        st_d     = from_rst_q ? ST_CLK_ON_RESET : ST_RUN;
                        ovl_load = 1'b1;
                    end
                end
                ST_CLK_ON_RESET: begin
                    if (ovl_zero) st_d = ST_RUN;
                end
                ST_RUN: begin
                    if (pwr_down) st_d = ST_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q       <= ST_WAIT_OSC;
            from_rst_q <= 1'b1;
        end else begin
            st_q       <= st_d;
            from_rst_q <= from_rst_d;
        end
    end

    // outputs
    always_comb begin
        clk_en   = ((st_q == ST_CLK_ON_RESET) || (st_q == ST_RUN)) && !rst_active;
        core_rst = rst_active || ((st_q == ST_WAIT_OSC) && from_rst_q) ||
                   (st_q == ST_CLK_ON_RESET);
    end

    a_r2_reset_restarts: assert property (@(posedge clk) disable iff (!por_n)
        rst_active |=> (st_q == ST_WAIT_OSC) && from_rst_q)
        else $error("a_r2_reset_restarts");

    a_r4_hold_until_zero: assert property (@(posedge clk) disable iff (!por_n)
        ((st_q == ST_WAIT_OSC) && !wait_zero && !rst_active) |=> (st_q == ST_WAIT_OSC))
        else $error("a_r4_hold_until_zero");

    a_r5_reset_path: assert property (@(posedge clk) disable iff (!por_n)
        ((st_q == ST_WAIT_OSC) && wait_zero && from_rst_q && !rst_active)
            |=> (st_q == ST_CLK_ON_RESET))
        else $error("a_r5_reset_path");

    a_r5_overlap_end: assert property (@(posedge clk) disable iff (!por_n)
        ((st_q == ST_CLK_ON_RESET) && ovl_zero && !rst_active) |=> (st_q == ST_RUN))
        else $error("a_r5_overlap_end");

    a_r6_wake_no_reset: assert property (@(posedge clk) disable iff (!por_n)
        ((st_q == ST_IDLE) && wake_req && !rst_active)
            |=> (st_q == ST_WAIT_OSC) && !from_rst_q)
        else $error("a_r6_wake_no_reset");

    a_r7_sleep: assert property (@(posedge clk) disable iff (!por_n)
        ((st_q == ST_RUN) && pwr_down && !rst_active) |=> (st_q == ST_IDLE))
        else $error("a_r7_sleep");

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!por_n)
        (st_q == ST_IDLE) |-> !clk_en && (core_rst == rst_active))
        else $error("a_r7_idle_quiet");

endmodule

// File: tb/tb_rst_stretch_seq.sv
`timescale 1ns/1ps
module tb_rst_stretch_seq;
    localparam int FILT  = 3;
    localparam int LONGT = 20;
    localparam int SHRT  = 5;
    localparam int OVL   = 4;
    localparam int TPER  = 7;

    logic clk = 1'b0;
    logic por_n, ext_rst_in, wake_req, osc_running, tick_32k, pwr_down;
    logic clk_en, core_rst;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    string cur_req = "R8";

    always #2.5 clk = ~clk;

    rst_stretch_seq #(
        .FILT_CYC(FILT), .LONG_TICKS(LONGT), .SHORT_TICKS(SHRT), .OVL_CYC(OVL)
    ) dut (
        .clk(clk), .por_n(por_n), .ext_rst_in(ext_rst_in), .wake_req(wake_req),
        .osc_running(osc_running), .tick_32k(tick_32k), .pwr_down(pwr_down),
        .clk_en(clk_en), .core_rst(core_rst)
    );

    task automatic check(string req, string what, logic got, logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic check_rng(string req, string what, int got, int lo, int hi);
        n_tests++;
        if (got < lo || got > hi) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d..%0d", req, what, got, lo, hi);
        end
    endtask

    // free-running 32 kHz strobe
    initial begin
        tick_32k = 1'b0;
        forever begin
            repeat (TPER - 1) @(negedge clk);
            tick_32k = 1'b1;
            @(negedge clk);
            tick_32k = 1'b0;
        end
    end

    // behavioural reference: mode 0 sleeping, 1 waiting, 2 overlap, 3 running
    int m_p1, m_p2, m_hi, m_mode, m_wait, m_ovl, m_rstkind;
    always @(posedge clk or negedge por_n) begin
        int was_act, p2_old;
        if (!por_n) begin
            m_p1 = 0; m_p2 = 0; m_hi = 0;
            m_mode = 1; m_wait = LONGT; m_ovl = 0; m_rstkind = 1;
        end else begin
            was_act = (m_hi >= FILT) ? 1 : 0;
            p2_old  = m_p2;
            m_p2    = m_p1;
            m_p1    = ext_rst_in ? 1 : 0;
            m_hi    = (p2_old != 0) ? ((m_hi < FILT) ? m_hi + 1 : FILT) : 0;
            if (was_act != 0) begin
                m_mode = 1; m_rstkind = 1;
                m_wait = osc_running ? SHRT : LONGT;
            end else if (m_mode == 0) begin
                if (wake_req) begin
                    m_mode = 1; m_rstkind = 0;
                    m_wait = osc_running ? SHRT : LONGT;
                end
            end else if (m_mode == 1) begin
                if (m_wait == 0) begin
                    m_mode = (m_rstkind != 0) ? 2 : 3;
                    m_ovl  = OVL - 1;
                end else if (tick_32k) m_wait--;
            end else if (m_mode == 2) begin
                if (m_ovl == 0) m_mode = 3; else m_ovl--;
            end else if (pwr_down) m_mode = 0;
        end
    end

    // per-cycle comparison plus event counters
    int ovl_seen = 0;
    int rst_seen = 0;
    always @(negedge clk) begin
        logic e_act, e_clk, e_rst;
        if (por_n && !finished) begin
            e_act = (m_hi >= FILT);
            e_clk = (m_mode >= 2) && !e_act;
            e_rst = e_act || (m_mode == 1 && m_rstkind != 0) || (m_mode == 2);
            check(cur_req, "clk_en vs model", clk_en, e_clk);
            check(cur_req, "core_rst vs model", core_rst, e_rst);
            if (clk_en && core_rst) ovl_seen++;
            if (core_rst) rst_seen++;
        end
    end

    task automatic wait_clk_en(output int n);
        n = 0;
        while (!clk_en && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse(ref logic sig, input int cyc);
        sig = 1'b1;
        repeat (cyc) @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        int n;
        por_n = 1'b0; ext_rst_in = 1'b0; wake_req = 1'b0;
        osc_running = 1'b0; pwr_down = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        // R8: power-on state
        check("R8", "clk_en after por", clk_en, 1'b0);
        check("R8", "core_rst after por", core_rst, 1'b1);

        // R4/R5: long wait then overlap
        cur_req = "R4";
        ovl_seen = 0;
        wait_clk_en(n);
        check_rng("R4", "long wait cycles", n, (LONGT - 1) * TPER, (LONGT + 1) * TPER + 3);
        cur_req = "R5";
        check("R5", "core_rst at clock start", core_rst, 1'b1);
        repeat (OVL + 2) @(negedge clk);
        check_rng("R5", "overlap cycles", ovl_seen, OVL, OVL);
        check("R5", "core_rst after overlap", core_rst, 1'b0);

        // R1: short pulse ignored
        cur_req = "R1";
        pulse(ext_rst_in, FILT - 1);
        repeat (6) @(negedge clk);
        check("R1", "clk_en after glitch", clk_en, 1'b1);
        check("R1", "core_rst after glitch", core_rst, 1'b0);

        // R7: wake ignored in run, sleep entry
        cur_req = "R7";
        pulse(wake_req, 1);
        @(negedge clk);
        check("R7", "clk_en after wake in run", clk_en, 1'b1);
        pulse(pwr_down, 1);
        check("R7", "clk_en in idle", clk_en, 1'b0);
        check("R7", "core_rst in idle", core_rst, 1'b0);
        pulse(pwr_down, 2);
        check("R7", "clk_en after pwr_down in idle", clk_en, 1'b0);

        // R6/R3: wake with oscillator running, short wait
        cur_req = "R6";
        osc_running = 1'b1;
        rst_seen = 0;
        pulse(wake_req, 1);
        wait_clk_en(n);
        check_rng("R3", "short wake wait cycles", n, (SHRT - 1) * TPER, (SHRT + 1) * TPER + 3);
        repeat (3) @(negedge clk);
        check_rng("R6", "core_rst cycles on wake", rst_seen, 0, 0);

        // R2: reset in run
        cur_req = "R2";
        ext_rst_in = 1'b1;
        repeat (FILT + 2) @(negedge clk);
        check("R2", "clk_en under reset", clk_en, 1'b0);
        check("R2", "core_rst under reset", core_rst, 1'b1);
        repeat (3) @(negedge clk);
        ext_rst_in = 1'b0;
        cur_req = "R3";
        wait_clk_en(n);
        check_rng("R3", "short reset wait cycles", n, (SHRT - 1) * TPER, (SHRT + 3) * TPER);
        check("R5", "core_rst at clock start", core_rst, 1'b1);

        // R2: reset during overlap, then long wait
        cur_req = "R2";
        osc_running = 1'b0;
        ext_rst_in = 1'b1;
        repeat (FILT + 2) @(negedge clk);
        check("R2", "clk_en reset in overlap", clk_en, 1'b0);
        check("R2", "core_rst reset in overlap", core_rst, 1'b1);
        ext_rst_in = 1'b0;
        cur_req = "R3";
        wait_clk_en(n);
        check_rng("R3", "long reset wait cycles", n, (LONGT - 1) * TPER, (LONGT + 3) * TPER);
        repeat (OVL + 2) @(negedge clk);

        // R6/R7: wake with oscillator stopped, pwr_down during wait ignored
        cur_req = "R6";
        pulse(pwr_down, 1);
        rst_seen = 0;
        pulse(wake_req, 1);
        repeat (10) @(negedge clk);
        pulse(pwr_down, 1);
        check("R7", "clk_en pwr_down in wait", clk_en, 1'b0);
        wait_clk_en(n);
        check_rng("R3", "long wake wait cycles", n + 11, (LONGT - 1) * TPER, (LONGT + 1) * TPER + 3);
        repeat (3) @(negedge clk);
        check("R6", "clk_en after long wake", clk_en, 1'b1);
        check_rng("R6", "core_rst cycles on long wake", rst_seen, 0, 0);

        summary();
    end
endmodule